// File: doc/BRIEF.md
# Dual-Mode Serial Loader with Status Readback

This block is the serial front end of a sixteen-channel LED driver. A host streams data into it over a shift interface made of a data input, a shift clock and a latch strobe, all sampled by the system clock. A mode input selects the destination. In grayscale mode the chain is 192 bits long and feeds a register holding one 12-bit brightness word per channel. In dot-correction mode the chain is 96 bits long and feeds a register holding one 6-bit current trim per channel.

After a grayscale commit, the shift chain is refilled with a status packet. The host reads this packet back through the data output while it shifts the next frame in. The data output also lets several blocks be chained, each output feeding the next block's data input. A single pending flag tracks the rule that the first grayscale commit after a dot-correction load only completes on one extra shift clock.

Top module: `lp_serial_loader`

## Requirements
- R1: While reset is applied and after it is released, the grayscale register, the dot-correction register and the data output all read zero.
- R2: A rising shift-clock edge moves the chain up by one bit and takes `sdi` into bit 0, so the first bit sent ends up as the most significant bit. Within a word, channel 15 is sent first and each word is sent MSB first.
- R3: The data output taps bit 191 of the chain in grayscale mode (`mode_dc`=0) and bit 95 in dot-correction mode (`mode_dc`=1). A bit therefore leaves after 192 or after 96 shift clocks.
- R4: A rising latch edge in grayscale mode, with no extra clock pending, copies the 192-bit chain into `gs_data` (channel n at bits 12n+11..12n). `dc_data` is left unchanged.
- R5: A rising latch edge in dot-correction mode copies the low 96 bits of the chain into `dc_data` (channel n at bits 6n+5..6n). `gs_data` is left unchanged and the chain is not reloaded.
- R6: Each grayscale commit reloads the chain with a status packet. Bit 176+n holds `open_flags[n]`, bit 175 holds `therm_flag`, and bits 167..72 hold a dot-correction image. All other bits are zero.
- R7: The dot-correction image in the status packet is `dc_stored` when `dc_src_live`=0 and the current `dc_data` when `dc_src_live`=1.
- R8: After a dot-correction load, the next grayscale latch edge does not change `gs_data`. The following rising shift-clock edge then performs the commit and the status reload, and its `sdi` bit is discarded. Later grayscale latches commit at once.
- R9: `sdo` changes only on a falling shift-clock edge, or in the cycle after a status reload, when it shows the packet's top bit.
- R10: The mode input is taken only while the latch strobe is low. A change made while the strobe is held high has no effect.
- R11: Shifting 193 bits and latching in grayscale mode leaves `gs_data` equal to the last 192 bits sent, whatever came first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all interface pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Shift clock |
| sdi | input | 1 | Serial data input |
| latch | input | 1 | Commit strobe, rising edge active |
| mode_dc | input | 1 | 1 = dot-correction destination, 0 = grayscale |
| dc_src_live | input | 1 | Status image source: 1 = live register, 0 = stored copy |
| open_flags | input | 16 | Per-channel open-load flags |
| therm_flag | input | 1 | Over-temperature flag |
| dc_stored | input | 96 | Stored default dot-correction image |
| sdo | output | 1 | Serial data output toward the next block |
| gs_data | output | 192 | Grayscale holding register |
| dc_data | output | 96 | Dot-correction holding register |

## Verification
The bench builds the block with its default parameters: 16 channels, 12-bit grayscale words and 6-bit trim words. This gives full 192-bit and 96-bit frames, so the exact status field positions and both tap points are exercised. The bench covers the dummy-bit recovery load, the deferred commit after a trim load, and both image sources. It also holds the strobe high through a mode change to show that the change is ignored.

// File: rtl/lp_serial_pkg.sv
package lp_serial_pkg;
  // reserved bits between the thermal bit and the trim image in the status packet
  localparam int unsigned STAT_GAP = 7;

  typedef enum logic [1:0] {
    CH_HOLD   = 2'd0,
    CH_SHIFT  = 2'd1,
    CH_STATUS = 2'd2
  } chain_op_e;
endpackage

// File: rtl/lp_latch_ctrl.sv
module lp_latch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic latch,
  input  logic mode_dc,
  output logic mode_q,
  output logic shift_en,
  output logic sclk_fall,
  output logic gs_load,
  output logic dc_load,
  output logic sdo_refresh
);
  logic sclk_q, latch_q, pend_q, arm_q, refresh_q;
  logic sclk_d, latch_d, mode_d, pend_d, arm_d, refresh_d;
  logic sclk_rise, latch_rise, gs_now, gs_defer, gs_late;

  always_comb begin
    sclk_rise  = sclk & ~sclk_q;
    sclk_fall  = ~sclk & sclk_q;
    latch_rise = latch & ~latch_q;
    dc_load    = latch_rise & mode_q;
    gs_now     = latch_rise & ~mode_q & ~pend_q;
    gs_defer   = latch_rise & ~mode_q & pend_q;
    gs_late    = arm_q & sclk_rise & ~latch_rise;
    gs_load    = gs_now | gs_late;
    shift_en   = sclk_rise & ~latch_rise & ~gs_late;
    sdo_refresh = refresh_q;
  end

  always_comb begin
    sclk_d    = sclk;
    latch_d   = latch;
    mode_d    = latch ? mode_q : mode_dc;
    refresh_d = gs_load;
    pend_d    = pend_q;
    arm_d     = arm_q;
    if (dc_load) begin
      pend_d = 1'b1;
      arm_d  = 1'b0;
    end else if (gs_defer) begin
      arm_d  = 1'b1;
    end else if (gs_late) begin
      pend_d = 1'b0;
      arm_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      latch_q   <= 1'b0;
      mode_q    <= 1'b0;
      pend_q    <= 1'b0;
      arm_q     <= 1'b0;
      refresh_q <= 1'b0;
    end else begin
      sclk_q    <= sclk_d;
      latch_q   <= latch_d;
      mode_q    <= mode_d;
      pend_q    <= pend_d;
      arm_q     <= arm_d;
      refresh_q <= refresh_d;
    end
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && $past(latch)) |=> $stable(mode_q)); // R10
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(arm_q && sclk_rise)); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dc_load, gs_load, shift_en})); // R4
endmodule

// File: rtl/lp_status_pack.sv
module lp_status_pack #(
  parameter int unsigned CH     = 16,
  parameter int unsigned GS_LEN = 192,
  parameter int unsigned DC_LEN = 96
) (
  input  logic [CH-1:0]     open_flags,
  input  logic              therm_flag,
  input  logic              dc_src_live,
  input  logic [DC_LEN-1:0] dc_live,
  input  logic [DC_LEN-1:0] dc_stored,
  output logic [GS_LEN-1:0] status
);
  import lp_serial_pkg::*;
  localparam int unsigned FLAG_LSB = GS_LEN - CH;
  localparam int unsigned TEMP_POS = FLAG_LSB - 1;
  localparam int unsigned IMG_MSB  = TEMP_POS - STAT_GAP - 1;
  localparam int unsigned IMG_LSB  = IMG_MSB - DC_LEN + 1;

  logic [DC_LEN-1:0] image;
  logic [GS_LEN-1:0] flag_part, temp_part, img_part;

  assign image = dc_src_live ? dc_live : dc_stored;

  for (genvar b = 0; b < GS_LEN; b++) begin : g_bit
    if (b >= FLAG_LSB) begin : g_flag
      assign flag_part[b] = open_flags[b - FLAG_LSB];
    end else begin : g_noflag
      assign flag_part[b] = 1'b0;
    end
    if (b == TEMP_POS) begin : g_temp
      assign temp_part[b] = therm_flag;
    end else begin : g_notemp
      assign temp_part[b] = 1'b0;
    end
    if (b >= IMG_LSB && b <= IMG_MSB) begin : g_img
      assign img_part[b] = image[b - IMG_LSB];
    end else begin : g_noimg
      assign img_part[b] = 1'b0;
    end
  end

  assign status = flag_part | temp_part | img_part;
endmodule

// File: rtl/lp_shift_chain.sv
module lp_shift_chain #(
  parameter int unsigned GS_LEN = 192,
  parameter int unsigned DC_LEN = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              mode_q,
  input  logic              shift_en,
  input  logic              sclk_fall,
  input  logic              status_load,
  input  logic              sdo_refresh,
  input  logic [GS_LEN-1:0] status,
  output logic [GS_LEN-1:0] chain_q,
  output logic              sdo
);
  import lp_serial_pkg::*;
  chain_op_e         op;
  logic [GS_LEN-1:0] chain_d;
  logic              sdo_q, sdo_d, tap;

  always_comb begin
    if (status_load)   op = CH_STATUS;
    else if (shift_en) op = CH_SHIFT;
    else               op = CH_HOLD;
    case (op)
      CH_STATUS: chain_d = status;
      CH_SHIFT:  chain_d = {chain_q[GS_LEN-2:0], sdi};
      default:   chain_d = chain_q;
    endcase
    tap   = mode_q ? chain_q[DC_LEN-1] : chain_q[GS_LEN-1];
    sdo_d = (sclk_fall || sdo_refresh) ? tap : sdo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      sdo_q   <= 1'b0;
    end else begin
      chain_q <= chain_d;
      sdo_q   <= sdo_d;
    end
  end

  assign sdo = sdo_q;

  AST_SDO_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(sclk_fall || sdo_refresh)); // R9
  AST_STATUS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    status_load |=> (chain_q == $past(status))); // R6
endmodule

// File: rtl/lp_hold_bank.sv
module lp_hold_bank #(
  parameter int unsigned GS_LEN = 192,
  parameter int unsigned DC_LEN = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gs_load,
  input  logic              dc_load,
  input  logic [GS_LEN-1:0] chain_q,
  output logic [GS_LEN-1:0] gs_q,
  output logic [DC_LEN-1:0] dc_q
);
  logic [GS_LEN-1:0] gs_d;
  logic [DC_LEN-1:0] dc_d;

  always_comb begin
    gs_d = gs_load ? chain_q : gs_q;
    dc_d = dc_load ? chain_q[DC_LEN-1:0] : dc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs_q <= '0;
      dc_q <= '0;
    end else begin
      gs_q <= gs_d;
      dc_q <= dc_d;
    end
  end

  AST_GS_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gs_q) |-> $past(gs_load)); // R4
  AST_DC_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dc_q) |-> $past(dc_load)); // R5
endmodule

// File: rtl/lp_serial_loader.sv
module lp_serial_loader #(
  parameter int unsigned CH      = 16,
  parameter int unsigned GS_BITS = 12,
  parameter int unsigned DC_BITS = 6,
  localparam int unsigned GS_LEN = CH * GS_BITS,
  localparam int unsigned DC_LEN = CH * DC_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              latch,
  input  logic              mode_dc,
  input  logic              dc_src_live,
  input  logic [CH-1:0]     open_flags,
  input  logic              therm_flag,
  input  logic [DC_LEN-1:0] dc_stored,
  output logic              sdo,
  output logic [GS_LEN-1:0] gs_data,
  output logic [DC_LEN-1:0] dc_data
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              mode_q, shift_en, sclk_fall, gs_load, dc_load, sdo_refresh;
  logic [GS_LEN-1:0] status, chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lp_latch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .sclk(sclk), .latch(latch), .mode_dc(mode_dc),
    .mode_q(mode_q), .shift_en(shift_en), .sclk_fall(sclk_fall),
    .gs_load(gs_load), .dc_load(dc_load), .sdo_refresh(sdo_refresh)
  );

  lp_status_pack #(.CH(CH), .GS_LEN(GS_LEN), .DC_LEN(DC_LEN)) u_status (
    .open_flags(open_flags), .therm_flag(therm_flag), .dc_src_live(dc_src_live),
    .dc_live(dc_data), .dc_stored(dc_stored), .status(status)
  );

  lp_shift_chain #(.GS_LEN(GS_LEN), .DC_LEN(DC_LEN)) u_chain (
    .clk(clk), .rst_n(rst_int_n), .sdi(sdi), .mode_q(mode_q), .shift_en(shift_en),
    .sclk_fall(sclk_fall), .status_load(gs_load), .sdo_refresh(sdo_refresh),
    .status(status), .chain_q(chain_q), .sdo(sdo)
  );

  lp_hold_bank #(.GS_LEN(GS_LEN), .DC_LEN(DC_LEN)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .gs_load(gs_load), .dc_load(dc_load),
    .chain_q(chain_q), .gs_q(gs_data), .dc_q(dc_data)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_int_n |=> (gs_data == '0 && dc_data == '0)); // R1
endmodule

// File: tb/lp_serial_loader_test.sv
module lp_serial_loader_test;
  logic clk = 1'b0;
  logic rst_n, sclk, sdi, latch, mode_dc, dc_src_live, therm_flag;
  logic [15:0]  open_flags;
  logic [95:0]  dc_stored;
  logic         sdo;
  logic [191:0] gs_data;
  logic [95:0]  dc_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lp_serial_loader uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .latch(latch),
    .mode_dc(mode_dc), .dc_src_live(dc_src_live), .open_flags(open_flags),
    .therm_flag(therm_flag), .dc_stored(dc_stored), .sdo(sdo),
    .gs_data(gs_data), .dc_data(dc_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [191:0] gs_pat(input int seed);
    logic [191:0] v;
    for (int n = 0; n < 16; n++) v[n*12 +: 12] = 12'((n * 273 + seed) & 12'hFFF);
    return v;
  endfunction

  function automatic logic [95:0] dc_pat(input int mul, input int add);
    logic [95:0] v;
    for (int n = 0; n < 16; n++) v[n*6 +: 6] = 6'((n * mul + add) & 6'h3F);
    return v;
  endfunction

  function automatic logic [191:0] exp_status(input logic [15:0] f, input logic t,
                                              input logic [95:0] d);
    logic [191:0] s = '0;
    for (int c = 0; c < 16; c++) s[176 + c] = f[c];
    s[175] = t;
    for (int i = 0; i < 96; i++) s[72 + i] = d[i];
    return s;
  endfunction

  // behavioural reference, stepped on every clock
  logic [191:0] m_sr, m_gs;
  logic [95:0]  m_dc;
  logic m_sdo, m_pend, m_arm, m_ref, m_mode, m_psclk, m_plat;
  int   since = 0;
  bit   m_on = 0;

  always @(posedge clk) begin
    if (!rst_n || since < 3) begin
      m_sr = '0; m_gs = '0; m_dc = '0; m_sdo = 0; m_pend = 0; m_arm = 0;
      m_ref = 0; m_mode = 0; m_psclk = 0; m_plat = 0;
      since = rst_n ? since + 1 : 0;
      m_on = 0;
    end else begin
      bit srise, sfall, lrise, nref;
      logic [191:0] st;
      m_on  = 1;
      srise = sclk && !m_psclk;
      sfall = !sclk && m_psclk;
      lrise = latch && !m_plat;
      st    = exp_status(open_flags, therm_flag, dc_src_live ? m_dc : dc_stored);
      if (sfall || m_ref) m_sdo = m_mode ? m_sr[95] : m_sr[191];
      nref = 0;
      if (lrise && m_mode) begin
        m_dc = m_sr[95:0]; m_pend = 1; m_arm = 0;
      end else if (lrise && !m_pend) begin
        m_gs = m_sr; m_sr = st; nref = 1;
      end else if (lrise) begin
        m_arm = 1;
      end else if (srise && m_arm) begin
        m_gs = m_sr; m_sr = st; m_pend = 0; m_arm = 0; nref = 1;
      end else if (srise) begin
        m_sr = {m_sr[190:0], sdi};
      end
      m_ref = nref;
      if (!latch) m_mode = mode_dc;
      m_psclk = sclk;
      m_plat  = latch;
    end
  end

  always @(negedge clk) begin
    if (m_on && !done) begin
      chk(sdo == m_sdo, "R9", "sdo vs model", 192'(sdo), 192'(m_sdo));
      chk(gs_data == m_gs, "R4", "gs vs model", gs_data, m_gs);
      chk(dc_data == m_dc, "R5", "dc vs model", 192'(dc_data), 192'(m_dc));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; sclk = 1'b1; tick(2);
    sclk = 1'b0; tick(2);
  endtask

  task automatic send_vec(input logic [191:0] v, input int len);
    for (int i = len - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_latch();
    latch = 1'b1; tick(2);
    latch = 1'b0; tick(2);
  endtask

  task automatic read_out(input int len, output logic [191:0] got);
    logic q[$];
    got = '0;
    for (int i = 0; i < len; i++) begin
      q.push_back(sdo);
      send_bit(1'b0);
    end
    for (int i = 0; i < len; i++) got[len - 1 - i] = q[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [191:0] p1, p2, p3, got, st;
    logic [95:0]  dcp, dcs;
    rst_n = 0; sclk = 0; sdi = 0; latch = 0; mode_dc = 0; dc_src_live = 0;
    therm_flag = 0; open_flags = '0;
    dcs = dc_pat(11, 1);
    dc_stored = dcs;
    tick(4);
    chk(gs_data == '0 && dc_data == '0 && sdo == 0, "R1", "outputs in reset",
        gs_data, '0);
    rst_n = 1; tick(6);
    chk(gs_data == '0 && dc_data == '0 && sdo == 0, "R1", "outputs after release",
        gs_data, '0);

    // R11 / R2 / R4: dummy bit then a full grayscale frame
    open_flags = 16'hA5C3; therm_flag = 1;
    p1 = gs_pat(5);
    send_bit(1'b1);
    send_vec(p1, 192);
    pulse_latch();
    chk(gs_data == p1, "R11", "gs after 193-bit load", gs_data, p1);
    chk(gs_data[15*12 +: 12] == 12'((15 * 273 + 5) & 12'hFFF), "R2",
        "channel 15 word", 192'(gs_data[191:180]), 192'((15 * 273 + 5) & 12'hFFF));
    chk(dc_data == '0, "R4", "dc untouched by gs latch", 192'(dc_data), '0);

    // R6 / R7 / R3: status readback with stored image
    st = exp_status(16'hA5C3, 1'b1, dcs);
    read_out(192, got);
    chk(got == st, "R6", "status packet stored image", got, st);
    chk(got[167:72] == dcs, "R7", "stored image field", 192'(got[167:72]), 192'(dcs));
    chk(got[191:176] == 16'hA5C3 && got[175], "R3", "192-bit readout length",
        192'(got[191:175]), 192'({16'hA5C3, 1'b1}));
    pulse_latch();
    chk(gs_data == '0, "R4", "gs after zero frame", gs_data, '0);

    // R5 / R3: dot-correction load and 96-bit readout
    mode_dc = 1; tick(3);
    dcp = dc_pat(7, 3);
    send_vec(192'(dcp), 96);
    pulse_latch();
    chk(dc_data == dcp, "R5", "dc after load", 192'(dc_data), 192'(dcp));
    chk(gs_data == '0, "R5", "gs untouched by dc latch", gs_data, '0);
    read_out(96, got);
    chk(got[95:0] == dcp, "R3", "96-bit readout", 192'(got[95:0]), 192'(dcp));

    // R8: deferred commit after a dot-correction load
    mode_dc = 0; dc_src_live = 1; open_flags = 16'h0F0F; therm_flag = 0; tick(3);
    p2 = gs_pat(77);
    send_vec(p2, 192);
    pulse_latch();
    chk(gs_data == '0, "R8", "gs held at first latch", gs_data, '0);
    send_bit(1'b1);
    chk(gs_data == p2, "R8", "gs after extra clock", gs_data, p2);
    read_out(192, got);
    st = exp_status(16'h0F0F, 1'b0, dcp);
    chk(got == st, "R7", "status packet live image", got, st);
    pulse_latch();
    chk(gs_data == '0, "R8", "later latch commits at once", gs_data, '0);

    // R10: mode change while strobe held high is ignored
    p3 = gs_pat(901);
    send_vec(p3, 192);
    latch = 1; tick(2);
    chk(gs_data == p3, "R10", "gs commit before mode test", gs_data, p3);
    mode_dc = 1; tick(3);
    latch = 0; mode_dc = 0; tick(3);
    latch = 1; tick(2);
    latch = 0; tick(2);
    st = exp_status(16'h0F0F, 1'b0, dcp);
    chk(dc_data == dcp, "R10", "dc unchanged", 192'(dc_data), 192'(dcp));
    chk(gs_data == st, "R10", "second latch went to gs", gs_data, st);

    tick(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule